// File: doc/BRIEF.md
# Modem Reset and Bring-up Sequencer

This block sits on the host side of an attached modem and runs its reset. A start request drives the modem's active-low reset output low. The length of that pulse depends on the clock source the modem was built with: a short pulse for the fast crystal or external clock option, and a much longer one for the slow 32 kHz crystal. When the pulse ends, the block waits through a fixed recovery interval. Only after that interval does it raise a ready flag, which allows command traffic to the modem.

A software-reset notice covers the case where the host has reset the modem by command or by register bit. That path skips the pulse but still waits the full recovery interval. The modem's interrupt line may toggle while its strap pins are being sampled, so the block holds the host-facing interrupt masked from the start of any reset until ready.

Every reset returns the modem to its defaults. For that reason the block then walks through a fixed series of configuration phases: firmware load (phase 0), line-interface settings (phase 1) and tone cadence values (phase 2). It hands each phase to host logic with a request and waits for a done pulse. Phases with nothing to load can be masked off. All intervals are counted in millisecond ticks derived from the system clock frequency parameter.

Top module: `modem_reset_seq`

## Requirements
- R1: After block reset: `modem_rst_n` = 1, `ready` = 0, `cfg_done` = 0, `phase_req` = 0 and `irq_out` = 0.
- R2: A `start_req` sampled with `clk_sel_slow` = 0 drives `modem_rst_n` low from the next cycle for FAST_PULSE_MS milliseconds (within one millisecond tick).
- R3: A `start_req` sampled with `clk_sel_slow` = 1 drives `modem_rst_n` low for SLOW_PULSE_MS milliseconds (within one tick).
- R4: After `modem_rst_n` returns high, `ready` stays 0 for RECOVER_MS milliseconds (within one tick) under either clock option, then rises. `ready` is never 1 while `modem_rst_n` is 0.
- R5: A `sw_reset` sampled without `start_req` leaves `modem_rst_n` high, drops `ready` in the next cycle, and raises it again after RECOVER_MS milliseconds.
- R6: `irq_out` is 0 whenever `ready` is 0, whatever `irq_in` does. While `ready` is 1, `irq_out` follows `irq_in`.
- R7: When `ready` rises, `phase_req` is one-hot on the lowest-numbered enabled phase. Bit i of `phase_req`, `phase_en` and `phase_done` belongs to phase i, and phases run in ascending order: 0 firmware, 1 line interface, 2 cadence.
- R8: The active phase changes only on a `phase_done` pulse on that phase's own bit. A done pulse on any other bit has no effect.
- R9: Phases whose `phase_en` bit is 0 are skipped. With no phase enabled, `cfg_done` rises together with `ready`.
- R10: After the done pulse of the last enabled phase, `phase_req` returns to 0 and `cfg_done` rises, with `ready` still 1.
- R11: A `start_req` in any state restarts the sequence from the pulse: `ready` and `cfg_done` fall, and the configuration phases run again afterwards. `start_req` takes priority over `sw_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start_req | input | 1 | Request a full hardware reset of the modem |
| sw_reset | input | 1 | Notice that a software reset was issued to the modem |
| clk_sel_slow | input | 1 | 1 = modem runs from the slow 32 kHz crystal; 0 = fast clock option |
| irq_in | input | 1 | Interrupt line from the modem |
| irq_out | output | 1 | Interrupt forwarded to the host, masked during reset |
| modem_rst_n | output | 1 | Active-low reset driven to the modem |
| ready | output | 1 | Command traffic to the modem is allowed |
| phase_en | input | NUM_PHASES | Per-phase enable mask |
| phase_done | input | NUM_PHASES | Per-phase completion pulse from host logic |
| phase_req | output | NUM_PHASES | One-hot request for the active configuration phase |
| cfg_done | output | 1 | All enabled configuration phases have completed |

## Verification
The hardest case to reach is a restart that lands in the middle of configuration. It needs a full pulse and recovery to have run, and it needs some phases already acknowledged. The bench first completes phase 0, then raises `start_req` while phase 1 is pending. It then checks that the pulse is re-timed from scratch and that phase 0 is requested again. Stray done pulses on bits that are not active are injected while a phase is pending. The long slow-clock pulse is measured cycle by cycle with a shortened tick so that the whole run stays short.

// File: rtl/modem_reset_seq.sv
module modem_reset_seq #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int FAST_PULSE_MS = 5,
  parameter int SLOW_PULSE_MS = 500,
  parameter int RECOVER_MS    = 300,
  parameter int NUM_PHASES    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic                  sw_reset,
  input  logic                  clk_sel_slow,
  input  logic                  irq_in,
  output logic                  irq_out,
  output logic                  modem_rst_n,
  output logic                  ready,
  input  logic [NUM_PHASES-1:0] phase_en,
  input  logic [NUM_PHASES-1:0] phase_done,
  output logic [NUM_PHASES-1:0] phase_req,
  output logic                  cfg_done
);

  localparam int TICK_DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int DW       = $clog2(TICK_DIV + 1);
  localparam int MAX_A    = (FAST_PULSE_MS > SLOW_PULSE_MS) ? FAST_PULSE_MS : SLOW_PULSE_MS;
  localparam int MAX_MS   = (MAX_A > RECOVER_MS) ? MAX_A : RECOVER_MS;
  localparam int MW       = $clog2(MAX_MS + 2);
  localparam int PW       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_RECOV, S_CFG, S_RUN} st_t;

  st_t           state;
  logic [DW-1:0] pre;
  logic [MW-1:0] ms;
  logic [MW-1:0] lim;
  logic [PW-1:0] cur;

  logic          tick, span_end;
  logic          first_ok, next_ok;
  logic [PW-1:0] first_idx, next_idx;

  assign tick     = (pre == DW'(TICK_DIV - 1));
  assign span_end = tick && (ms + MW'(1) == lim);

  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int i = NUM_PHASES - 1; i >= 0; i--) begin
      if (phase_en[i]) begin
        first_ok  = 1'b1;
        first_idx = PW'(i);
      end
      if (phase_en[i] && (i > int'(cur))) begin
        next_ok  = 1'b1;
        next_idx = PW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pre   <= '0;
      ms    <= '0;
      lim   <= '0;
      cur   <= '0;
    end else if (start_req) begin
      state <= S_PULSE;
      pre   <= '0;
      ms    <= '0;
      lim   <= clk_sel_slow ? MW'(SLOW_PULSE_MS) : MW'(FAST_PULSE_MS);
    end else if (sw_reset) begin
      state <= S_RECOV;
      pre   <= '0;
      ms    <= '0;
      lim   <= MW'(RECOVER_MS);
    end else begin
      case (state)
        S_PULSE, S_RECOV: begin
          if (!tick) begin
            pre <= pre + DW'(1);
          end else begin
            pre <= '0;
            ms  <= span_end ? '0 : ms + MW'(1);
          end
          if (span_end) begin
            if (state == S_PULSE) begin
              state <= S_RECOV;
              lim   <= MW'(RECOVER_MS);
            end else if (first_ok) begin
              state <= S_CFG;
              cur   <= first_idx;
            end else begin
              state <= S_RUN;
            end
          end
        end
        S_CFG: begin
          if (phase_done[cur]) begin
            if (next_ok) cur <= next_idx;
            else         state <= S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign modem_rst_n = (state != S_PULSE);
  assign ready       = (state == S_CFG) || (state == S_RUN);
  assign cfg_done    = (state == S_RUN);
  assign irq_out     = irq_in & ready;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_req
    assign phase_req[g] = (state == S_CFG) && (cur == PW'(g));
  end

  // R11
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !modem_rst_n && !ready && !cfg_done);

  // R5
  sw_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_reset && !start_req) |=> modem_rst_n && !ready);

  // R4
  no_ready_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modem_rst_n |-> !ready);

  // R7
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_req));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (phase_req == '0) && ready);

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_req != '0) && ((phase_done & phase_req) == '0) && !start_req && !sw_reset)
      |=> $stable(phase_req));

endmodule

// File: tb/tb_modem_reset_seq.sv
module tb_modem_reset_seq;
  localparam int CLK_HZ = 10_000;
  localparam int DIV    = 10;
  localparam int FASTC  = 5 * DIV;
  localparam int SLOWC  = 500 * DIV;
  localparam int RECC   = 300 * DIV;
  localparam int NP     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, sw_reset = 1'b0, clk_sel_slow = 1'b0, irq_in = 1'b0;
  logic [NP-1:0] phase_en = '1, phase_done = '0;
  logic irq_out, modem_rst_n, ready, cfg_done;
  logic [NP-1:0] phase_req;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  modem_reset_seq #(.CLK_HZ(CLK_HZ), .FAST_PULSE_MS(5), .SLOW_PULSE_MS(500),
                    .RECOVER_MS(300), .NUM_PHASES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sw_reset(sw_reset),
    .clk_sel_slow(clk_sel_slow), .irq_in(irq_in), .irq_out(irq_out),
    .modem_rst_n(modem_rst_n), .ready(ready), .phase_en(phase_en),
    .phase_done(phase_done), .phase_req(phase_req), .cfg_done(cfg_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - DIV) && (a <= e + DIV);
  endfunction

  task automatic pulse_start(input bit slow);
    @(negedge clk); clk_sel_slow = slow; start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic measure(output int low_c, output int rec_c, output int leaks);
    low_c = 0; rec_c = 0; leaks = 0;
    while (!modem_rst_n) begin
      low_c++;
      if (irq_out) leaks++;
      @(negedge clk);
    end
    while (!ready) begin
      rec_c++;
      if (irq_out) leaks++;
      @(negedge clk);
    end
  endtask

  task automatic done_bit(input int b);
    phase_done = NP'(1) << b;
    @(negedge clk); phase_done = '0;
  endtask

  task automatic t_reset_state();
    check(modem_rst_n && !ready && !cfg_done && phase_req == 0 && !irq_out,
          "R1", {modem_rst_n, ready, cfg_done, irq_out}, 4'b1000);
  endtask

  task automatic t_fast_full();
    int lc, rc, lk;
    phase_en = 3'b111; irq_in = 1'b1;
    pulse_start(1'b0);
    measure(lc, rc, lk);
    check(near(lc, FASTC), "R2", lc, FASTC);
    check(near(rc, RECC), "R4", rc, RECC);
    check(lk == 0, "R6 masked", lk, 0);
    check(irq_out == 1'b1, "R6 pass", irq_out, 1);
    check(phase_req == 3'b001, "R7 first", phase_req, 1);
    done_bit(2); done_bit(1);
    check(phase_req == 3'b001, "R8 stray", phase_req, 1);
    done_bit(0);
    check(phase_req == 3'b010, "R7 second", phase_req, 2);
    done_bit(1);
    check(phase_req == 3'b100, "R7 third", phase_req, 4);
    done_bit(2);
    check(phase_req == 0 && cfg_done && ready, "R10", {phase_req, cfg_done, ready}, 5'b00011);
    irq_in = 1'b0;
    @(negedge clk);
    check(irq_out == 1'b0, "R6 follow", irq_out, 0);
  endtask

  task automatic t_slow();
    int lc, rc, lk;
    phase_en = 3'b000;
    pulse_start(1'b1);
    check(!ready && !cfg_done, "R11 drop", ready, 0);
    measure(lc, rc, lk);
    check(near(lc, SLOWC), "R3", lc, SLOWC);
    check(near(rc, RECC), "R4 slow", rc, RECC);
    check(cfg_done && phase_req == 0, "R9 none", cfg_done, 1);
  endtask

  task automatic t_sw_reset();
    int c = 0, lowseen = 0;
    phase_en = 3'b111;
    @(negedge clk); sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
    check(!ready && modem_rst_n, "R5 entry", {ready, modem_rst_n}, 2'b01);
    while (!ready) begin
      c++;
      if (!modem_rst_n) lowseen++;
      @(negedge clk);
    end
    check(near(c, RECC), "R5 wait", c, RECC);
    check(lowseen == 0, "R5 no pulse", lowseen, 0);
    check(phase_req == 3'b001, "R5 reconfig", phase_req, 1);
  endtask

  task automatic t_skip();
    int lc, rc, lk;
    phase_en = 3'b110;
    pulse_start(1'b0);
    measure(lc, rc, lk);
    check(phase_req == 3'b010, "R9 skip0", phase_req, 2);
    done_bit(0);
    check(phase_req == 3'b010, "R8 ignore", phase_req, 2);
    done_bit(1);
    check(phase_req == 3'b100, "R9 next", phase_req, 4);
    done_bit(2);
    check(cfg_done, "R10 skip", cfg_done, 1);
  endtask

  task automatic t_restart_mid();
    int lc, rc, lk;
    phase_en = 3'b111;
    pulse_start(1'b0);
    measure(lc, rc, lk);
    done_bit(0);
    check(phase_req == 3'b010, "R11 setup", phase_req, 2);
    @(negedge clk); start_req = 1'b1; sw_reset = 1'b1; clk_sel_slow = 1'b0;
    @(negedge clk); start_req = 1'b0; sw_reset = 1'b0;
    check(!modem_rst_n && !ready, "R11 priority", {modem_rst_n, ready}, 0);
    measure(lc, rc, lk);
    check(near(lc, FASTC), "R11 pulse", lc, FASTC);
    check(phase_req == 3'b001, "R11 rerun", phase_req, 1);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fast_full();
    t_slow();
    t_sw_reset();
    t_skip();
    t_restart_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule